// File: doc/BRIEF.md
# Dual-Clock Lane-Enabled RAM with Selectable Aspect

A simple dual-port memory holding 4,608 bits, physically 256 words of two 9-bit lanes. The write side and the read side each have their own clock, chip select and address. Each side is given a view width of its own, 18 or 9 bits, fixed by parameter. A narrow view sees the same storage as 512 entries of 9 bits, the low address bit picking the lane. The two sides may use different widths, so data can be written in one shape and read back in the other.

Read data comes from a registered memory read. A parameter adds a second output register for timing. A pairing parameter puts two blocks side by side for 256 x 36 with four lane enables, or one above the other for 512 x 18. Deep pairing steers writes with the top address bit and selects the read word through a registered copy of that bit. The registered bit is delayed to line up with the read data. Pairing uses no logic other than these selects.

The single reset input is asynchronous and active low. Inside the block it is released in step with each clock domain.

Top module: `dcram_top`

## Requirements
- R1: On a rising write-clock edge with wr_cs high, each 9-bit lane k whose wr_en[k] is high stores wr_data[9k+8:9k]. Other lanes are left unchanged, and nothing is stored while wr_cs is low.
- R2: A read is captured on a rising read-clock edge with rd_cs high. With PIPE=0 its data is on rd_data right after that edge. With PIPE=1 it appears right after the next rising edge.
- R3: A read-clock edge with rd_cs low leaves rd_data unchanged. It also does not change the value due from the pipeline.
- R4: While rst_n is low, rd_data is zero. It stays zero until the first read after release returns its data.
- R5: An 18-bit view uses addr[7:0] as the word address. In an unpaired or wide-paired block, addr[8] has no effect.
- R6: A 9-bit write view stores wr_data[8:0] at entry wr_addr[8:0] when wr_en[0] is high. Entry a is word a>>1, with lane 0 (bits 8:0) when a[0]=0 and lane 1 when a[0]=1. wr_en[1] and wr_data[17:9] are ignored.
- R7: A 9-bit read view returns entry rd_addr[8:0] on rd_data[8:0], using the same mapping as R6. rd_data[17:9] reads as zero.
- R8: With different write and read widths, the data follows the mapping of R5 to R7 over the single shared storage.
- R9: If a write and a read reach the same word on the same clock edge, the read returns the data held before the write.
- R10: In a wide pair, data buses are 36 bits with lane k on bits 9k+8:9k and wr_en[k] as its enable, for k = 0 to 3. addr[7:0] is the word address.
- R11: In a deep pair, wr_addr[8] selects the block written: 0 selects the lower block and 1 the upper. The result is 512 distinct 18-bit words.
- R12: In a deep pair, rd_data comes from the block chosen by the rd_addr[8] captured with that read, for both settings of PIPE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, independent of wclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cs | input | 1 | Write chip select |
| wr_en | input | 2 (4 wide pair) | Per-lane write enables |
| wr_addr | input | 9 | Write address |
| wr_data | input | 18 (36 wide pair) | Write data |
| rd_cs | input | 1 | Read chip select |
| rd_addr | input | 9 | Read address |
| rd_data | output | 18 (36 wide pair) | Read data |

## Verification
A write counts as stored at the write-clock edge that captures it. A read returns what the storage held at its capture edge, and old data on an exact tie. Its value is due on rd_data one read-clock edge later with PIPE=0, and two edges later with PIPE=1. The bench model applies each write at its edge and keeps the lane's previous value and write time to settle ties. It runs its own read-side delay line and compares rd_data on every falling read-clock edge, half a period after the edge where the result is due. Six parameter sets run the same traffic: asynchronous clocks, then a narrow address window, then locked clocks to force same-edge collisions.

// File: rtl/dcram_pkg.sv
`timescale 1ns/1ps
package dcram_pkg;
  localparam int LANE_W     = 9;
  localparam int CORE_LANES = 2;
  localparam int CORE_W     = LANE_W * CORE_LANES;
  localparam int CORE_DEPTH = 256;
  localparam int CORE_AW    = $clog2(CORE_DEPTH);
  localparam int PORT_AW    = CORE_AW + 1;
  localparam int PAIR_NONE  = 0;
  localparam int PAIR_WIDE  = 1;
  localparam int PAIR_DEEP  = 2;
endpackage

// File: rtl/dcram_rst_sync.sv
`timescale 1ns/1ps
module dcram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dcram_core.sv
`timescale 1ns/1ps
module dcram_core #(
  parameter int LW    = dcram_pkg::LANE_W,
  parameter int LANES = dcram_pkg::CORE_LANES,
  parameter int DEPTH = dcram_pkg::CORE_DEPTH,
  localparam int W    = LW * LANES,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rword
);
  logic [W-1:0] mem [DEPTH];

  // lane-masked write port
  always_ff @(posedge wclk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
    end
  end

  // registered read; holds while not selected
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rword <= '0;
    else if (re)  rword <= mem[raddr];
  end
endmodule

// File: rtl/dcram_view.sv
`timescale 1ns/1ps
module dcram_view #(
  parameter int WR_W  = dcram_pkg::CORE_W,
  parameter int RD_W  = dcram_pkg::CORE_W,
  parameter int PIPE  = 0,
  parameter int LW    = dcram_pkg::LANE_W,
  parameter int LANES = dcram_pkg::CORE_LANES,
  parameter int DEPTH = dcram_pkg::CORE_DEPTH,
  localparam int W    = LW * LANES,
  localparam int AW   = $clog2(DEPTH),
  localparam int PAW  = AW + 1
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_cs,
  input  logic [LANES-1:0] wr_en,
  input  logic [PAW-1:0]   wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_cs,
  input  logic [PAW-1:0]   rd_addr,
  output logic [W-1:0]     rd_data
);
  logic [LANES-1:0] core_we;
  logic [AW-1:0]    core_waddr;
  logic [AW-1:0]    core_raddr;
  logic [W-1:0]     core_wd;
  logic [W-1:0]     core_word;
  logic [W-1:0]     sel_word;

  // ---------------- write side mapping ----------------
  generate
    if (WR_W == W) begin : g_wr_full
      logic unused_wr;
      assign unused_wr  = wr_addr[PAW-1];
      assign core_waddr = wr_addr[AW-1:0];
      assign core_wd    = wr_data;
      assign core_we    = (wr_cs && wrst_n) ? wr_en : '0;
    end else begin : g_wr_lane
      logic unused_wr;
      assign unused_wr  = ^{wr_en[LANES-1:1], wr_data[W-1:LW]};
      assign core_waddr = wr_addr[PAW-1:1];
      assign core_wd    = {LANES{wr_data[LW-1:0]}};
      always_comb begin
        core_we = '0;
        if (wr_cs && wrst_n && wr_en[0]) core_we[wr_addr[0]] = 1'b1;
      end
      a_r6_one_lane: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_cs && wr_en[0]) |-> $countones(core_we) == 1);
    end
  endgenerate

  a_r1_quiet_unselected: assert property (@(posedge wclk) disable iff (!wrst_n)
    !wr_cs |-> core_we == '0);

  dcram_core #(.LW(LW), .LANES(LANES), .DEPTH(DEPTH)) u_core (
    .wclk  (wclk),
    .we    (core_we),
    .waddr (core_waddr),
    .wdata (core_wd),
    .rclk  (rclk),
    .rrst_n(rrst_n),
    .re    (rd_cs),
    .raddr (core_raddr),
    .rword (core_word)
  );

  // ---------------- read side mapping ----------------
  generate
    if (RD_W == W) begin : g_rd_full
      logic unused_rd;
      assign unused_rd  = rd_addr[PAW-1];
      assign core_raddr = rd_addr[AW-1:0];
      assign sel_word   = core_word;
    end else begin : g_rd_lane
      logic half_q, half_d;
      assign core_raddr = rd_addr[PAW-1:1];
      always_comb half_d = rd_cs ? rd_addr[0] : half_q;
      always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) half_q <= 1'b0;
        else         half_q <= half_d;
      end
      assign sel_word = {{(W-LW){1'b0}},
                         (half_q ? core_word[2*LW-1:LW] : core_word[LW-1:0])};
      a_r7_upper_zero: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_cs |=> rd_data[W-1:LW] == '0);
    end
  endgenerate

  // ---------------- output stage ----------------
  generate
    if (PIPE != 0) begin : g_pipe
      logic         vld_q, vld_d;
      logic [W-1:0] out_q, out_d;
      always_comb begin
        vld_d = rd_cs;
        out_d = vld_q ? sel_word : out_q;
      end
      always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
          vld_q <= 1'b0;
          out_q <= '0;
        end else begin
          vld_q <= vld_d;
          out_q <= out_d;
        end
      end
      assign rd_data = out_q;
      a_r3_hold_piped: assert property (@(posedge rclk) disable iff (!rrst_n)
        !rd_cs |=> ##1 $stable(rd_data));
    end else begin : g_direct
      assign rd_data = sel_word;
      a_r3_hold_direct: assert property (@(posedge rclk) disable iff (!rrst_n)
        !rd_cs |=> $stable(rd_data));
    end
  endgenerate

  a_r4_reset_clear: assert property (@(posedge rclk) !rrst_n |-> rd_data == '0);
endmodule

// File: rtl/dcram_top.sv
`timescale 1ns/1ps
module dcram_top
  import dcram_pkg::*;
#(
  parameter int PAIR  = PAIR_NONE,
  parameter int WR_W  = CORE_W,
  parameter int RD_W  = CORE_W,
  parameter int PIPE  = 0,
  localparam int NB   = (PAIR == PAIR_WIDE) ? 2 : 1,
  localparam int DW   = CORE_W * NB,
  localparam int NL   = CORE_LANES * NB
) (
  input  logic               wclk,
  input  logic               rclk,
  input  logic               rst_n,
  input  logic               wr_cs,
  input  logic [NL-1:0]      wr_en,
  input  logic [PORT_AW-1:0] wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_cs,
  input  logic [PORT_AW-1:0] rd_addr,
  output logic [DW-1:0]      rd_data
);
  logic wrst_n;
  logic rrst_n;

  dcram_rst_sync #(.STAGES(2)) u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  dcram_rst_sync #(.STAGES(2)) u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  generate
    if (PAIR == PAIR_WIDE) begin : g_wide
      for (genvar b = 0; b < NB; b++) begin : g_blk
        dcram_view #(.WR_W(CORE_W), .RD_W(CORE_W), .PIPE(PIPE)) u_view (
          .wclk   (wclk),
          .wrst_n (wrst_n),
          .wr_cs  (wr_cs),
          .wr_en  (wr_en[b*CORE_LANES +: CORE_LANES]),
          .wr_addr(wr_addr),
          .wr_data(wr_data[b*CORE_W +: CORE_W]),
          .rclk   (rclk),
          .rrst_n (rrst_n),
          .rd_cs  (rd_cs),
          .rd_addr(rd_addr),
          .rd_data(rd_data[b*CORE_W +: CORE_W])
        );
      end
    end else if (PAIR == PAIR_DEEP) begin : g_deep
      logic [1:0]        blk_cs;
      logic [CORE_W-1:0] blk_data [2];
      logic              sel1_q, sel1_d;
      logic              sel_use;

      assign blk_cs[0] = wr_cs & ~wr_addr[CORE_AW];
      assign blk_cs[1] = wr_cs &  wr_addr[CORE_AW];

      for (genvar b = 0; b < 2; b++) begin : g_blk
        dcram_view #(.WR_W(CORE_W), .RD_W(CORE_W), .PIPE(PIPE)) u_view (
          .wclk   (wclk),
          .wrst_n (wrst_n),
          .wr_cs  (blk_cs[b]),
          .wr_en  (wr_en),
          .wr_addr(wr_addr),
          .wr_data(wr_data),
          .rclk   (rclk),
          .rrst_n (rrst_n),
          .rd_cs  (rd_cs),
          .rd_addr(rd_addr),
          .rd_data(blk_data[b])
        );
      end

      // block select travels with the read through the same stages
      always_comb sel1_d = rd_cs ? rd_addr[CORE_AW] : sel1_q;
      always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) sel1_q <= 1'b0;
        else         sel1_q <= sel1_d;
      end

      if (PIPE != 0) begin : g_sel_pipe
        logic rv_q, rv_d, sel2_q, sel2_d;
        always_comb begin
          rv_d   = rd_cs;
          sel2_d = rv_q ? sel1_q : sel2_q;
        end
        always_ff @(posedge rclk or negedge rrst_n) begin
          if (!rrst_n) begin
            rv_q   <= 1'b0;
            sel2_q <= 1'b0;
          end else begin
            rv_q   <= rv_d;
            sel2_q <= sel2_d;
          end
        end
        assign sel_use = sel2_q;
      end else begin : g_sel_direct
        assign sel_use = sel1_q;
      end

      assign rd_data = sel_use ? blk_data[1] : blk_data[0];

      a_r11_one_block: assert property (@(posedge wclk) disable iff (!wrst_n)
        $onehot0(blk_cs) && (wr_cs == (blk_cs != 2'b00)));
    end else begin : g_single
      dcram_view #(.WR_W(WR_W), .RD_W(RD_W), .PIPE(PIPE)) u_view (
        .wclk   (wclk),
        .wrst_n (wrst_n),
        .wr_cs  (wr_cs),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rclk   (rclk),
        .rrst_n (rrst_n),
        .rd_cs  (rd_cs),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
      );
    end
  endgenerate
endmodule

// File: tb/dcram_unit.sv
`timescale 1ns/1ps
module dcram_unit #(
  parameter int    PAIR = 0,
  parameter int    WR_W = 18,
  parameter int    RD_W = 18,
  parameter int    PIPE = 0,
  parameter int    SEED = 1,
  parameter string REQS = ""
) (
  input  logic wclk,
  input  logic rclk,
  input  logic rst_n,
  input  logic go,
  input  logic stop,
  input  logic tight,
  input  logic sync,
  output int   checks,
  output int   errors
);
  localparam int DW = (PAIR == 1) ? 36 : 18;
  localparam int LN = (PAIR == 1) ? 4 : 2;
  localparam int NL = (PAIR == 0) ? 512 : 1024;

  logic          wr_cs, rd_cs;
  logic [LN-1:0] wr_en;
  logic [8:0]    wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          fill_done = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  assign checks = n_chk;
  assign errors = n_err;

  dcram_top #(.PAIR(PAIR), .WR_W(WR_W), .RD_W(RD_W), .PIPE(PIPE)) u_dcram_top (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_cs(wr_cs), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_cs(rd_cs), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // lane-level reference storage: value, previous value, time of last write
  logic [8:0] lv [NL];
  logic [8:0] lp [NL];
  realtime    lt [NL];

  function automatic int word_base(logic [8:0] a);
    return ((PAIR == 2) ? int'(a) : int'(a[7:0])) * LN;
  endfunction

  function automatic logic [8:0] read_lane(int i);
    return (lt[i] == $realtime) ? lp[i] : lv[i];
  endfunction

  function automatic logic [DW-1:0] read_word(logic [8:0] a);
    logic [DW-1:0] r;
    r = '0;
    if (RD_W == 9 && PAIR == 0) r[8:0] = read_lane(int'(a));
    else for (int k = 0; k < LN; k++) r[9*k +: 9] = read_lane(word_base(a) + k);
    return r;
  endfunction

  task automatic put_lane(int i, logic [8:0] v);
    lp[i] = lv[i];
    lv[i] = v;
    lt[i] = $realtime;
  endtask

  initial for (int i = 0; i < NL; i++) begin
    lv[i] = '0; lp[i] = '0; lt[i] = -1.0;
  end

  // write model (R1, R5, R6, R10, R11)
  always @(posedge wclk) begin
    if (rst_n && wr_cs) begin
      if (WR_W == 9 && PAIR == 0) begin
        if (wr_en[0]) put_lane(int'(wr_addr), wr_data[8:0]);
      end else begin
        for (int k = 0; k < LN; k++)
          if (wr_en[k]) put_lane(word_base(wr_addr) + k, wr_data[9*k +: 9]);
      end
    end
  end

  // read-side delay line (R2, R3, R4, R7, R9, R12)
  logic [DW-1:0] exp_q = '0;
  logic [DW-1:0] s1 = '0;
  logic          s1v = 1'b0;
  always @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q = '0;
      s1v   = 1'b0;
    end else if (PIPE != 0) begin
      if (s1v) exp_q = s1;
      s1v = rd_cs;
      if (rd_cs) s1 = read_word(rd_addr);
    end else if (rd_cs) begin
      exp_q = read_word(rd_addr);
    end
  end

  always @(negedge rclk) begin
    n_chk++;
    if (rd_data !== exp_q) begin
      n_err++;
      $display("FAIL %s%s rd_data=%h expected=%h at %0t",
               (!rst_n ? "R4" : REQS), (sync ? " R9" : ""), rd_data, exp_q, $realtime);
    end
  end

  // write stimulus
  initial begin
    logic [31:0] r;
    logic [63:0] r64;
    void'($urandom(SEED));
    wr_cs = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0;
    wait (go);
    if (WR_W == 9 && PAIR == 0) begin
      for (int a = 0; a < 512; a++) begin
        @(negedge wclk);
        r64 = {$urandom, $urandom};
        wr_cs = 1'b1; wr_en = '1; wr_addr = 9'(a); wr_data = r64[DW-1:0];
      end
    end else begin
      for (int a = 0; a < ((PAIR == 2) ? 512 : 256); a++) begin
        @(negedge wclk);
        r = $urandom;
        r64 = {$urandom, $urandom};
        wr_cs = 1'b1; wr_en = '1; wr_data = r64[DW-1:0];
        wr_addr = (PAIR == 2) ? 9'(a) : {r[0], 8'(a)};
      end
    end
    @(negedge wclk);
    wr_cs = 1'b0;
    fill_done = 1'b1;
    while (!stop) begin
      @(negedge wclk);
      r = $urandom;
      r64 = {$urandom, $urandom};
      wr_cs   = (r[31:30] != 2'b00);
      wr_en   = r[LN-1:0];
      wr_addr = tight ? (r[16:8] & 9'h103) : r[16:8];
      wr_data = r64[DW-1:0];
    end
    @(negedge wclk);
    wr_cs = 1'b0;
  end

  // read stimulus
  initial begin
    logic [31:0] r;
    rd_cs = 1'b0; rd_addr = '0;
    wait (fill_done);
    while (!stop) begin
      @(negedge rclk);
      r = $urandom;
      rd_cs   = (r[31:30] != 2'b00);
      rd_addr = tight ? (r[8:0] & 9'h103) : r[8:0];
    end
    @(negedge rclk);
    rd_cs = 1'b0;
  end
endmodule

// File: tb/dcram_top_bench.sv
`timescale 1ns/1ps
module dcram_top_bench;
  logic wclk  = 1'b0;
  logic rfree = 1'b0;
  logic sync  = 1'b0;
  logic rst_n = 1'b1;
  logic go    = 1'b0;
  logic stop  = 1'b0;
  logic tight = 1'b0;
  logic rclk;
  logic ended = 1'b0;

  assign rclk = sync ? wclk : rfree;

  always #2.5 wclk  = ~wclk;   // 200 MHz write clock
  always #3.5 rfree = ~rfree;  // unrelated read clock

  int c [6];
  int e [6];

  // R1 R2 R3 R5: plain 18-bit views, direct read
  dcram_unit #(.PAIR(0), .WR_W(18), .RD_W(18), .PIPE(0), .SEED(11), .REQS("R1 R2 R3 R5"))
    u_a (.wclk(wclk), .rclk(rclk), .rst_n(rst_n), .go(go), .stop(stop), .tight(tight),
         .sync(sync), .checks(c[0]), .errors(e[0]));
  // R7 R8: wide write, narrow piped read
  dcram_unit #(.PAIR(0), .WR_W(18), .RD_W(9), .PIPE(1), .SEED(23), .REQS("R1 R2 R3 R5 R7 R8"))
    u_b (.wclk(wclk), .rclk(rclk), .rst_n(rst_n), .go(go), .stop(stop), .tight(tight),
         .sync(sync), .checks(c[1]), .errors(e[1]));
  // R6 R8: narrow write, wide direct read
  dcram_unit #(.PAIR(0), .WR_W(9), .RD_W(18), .PIPE(0), .SEED(37), .REQS("R2 R3 R5 R6 R8"))
    u_c (.wclk(wclk), .rclk(rclk), .rst_n(rst_n), .go(go), .stop(stop), .tight(tight),
         .sync(sync), .checks(c[2]), .errors(e[2]));
  // R6 R7: narrow on both sides, piped
  dcram_unit #(.PAIR(0), .WR_W(9), .RD_W(9), .PIPE(1), .SEED(41), .REQS("R2 R3 R6 R7"))
    u_d (.wclk(wclk), .rclk(rclk), .rst_n(rst_n), .go(go), .stop(stop), .tight(tight),
         .sync(sync), .checks(c[3]), .errors(e[3]));
  // R10: side-by-side pair, piped
  dcram_unit #(.PAIR(1), .WR_W(18), .RD_W(18), .PIPE(1), .SEED(53), .REQS("R1 R2 R10"))
    u_e (.wclk(wclk), .rclk(rclk), .rst_n(rst_n), .go(go), .stop(stop), .tight(tight),
         .sync(sync), .checks(c[4]), .errors(e[4]));
  // R11 R12: stacked pair, direct read
  dcram_unit #(.PAIR(2), .WR_W(18), .RD_W(18), .PIPE(0), .SEED(67), .REQS("R11 R12"))
    u_f (.wclk(wclk), .rclk(rclk), .rst_n(rst_n), .go(go), .stop(stop), .tight(tight),
         .sync(sync), .checks(c[5]), .errors(e[5]));

  task automatic finish_run(input bit timed_out);
    int tc, te;
    if (!ended) begin
      ended = 1'b1;
      tc = 0; te = 0;
      for (int i = 0; i < 6; i++) begin
        tc += c[i];
        te += e[i];
      end
      if (timed_out) begin
        tc++; te++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
      end
      $display("CHECKS %0d ERRORS %0d", tc, te);
      $finish;
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;                       // R4 reset state checked every read edge
    repeat (8) @(posedge wclk);
    rst_n = 1'b1;
    repeat (6) @(posedge wclk);
    go = 1'b1;
    repeat (3500) @(posedge wclk);         // asynchronous clocks, full address range
    tight = 1'b1;
    repeat (1500) @(posedge wclk);         // few addresses, dense reuse
    sync = 1'b1;
    repeat (1500) @(posedge wclk);         // R9: locked clocks force same-edge hits
    tight = 1'b0;
    repeat (1000) @(posedge wclk);
    stop = 1'b1;
    repeat (20) @(posedge wclk);
    rst_n = 1'b0;                          // R4: mid-run reset clears the output
    repeat (5) @(posedge wclk);
    rst_n = 1'b1;
    repeat (10) @(posedge wclk);
    finish_run(1'b0);
  end

  initial begin
    #(200000 * 5);
    finish_run(1'b1);
  end
endmodule